// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This unit sits between the operand-fetch logic of an 8-bit microcontroller core and that core's internal data storage. For each access it takes an addressing mode, a register number, an 8-bit address or pointer and the active bank selection. It resolves these to a single location in a 128-byte internal RAM, to the special-function window, to a rejected pointer, or to external data memory. The four banks of eight working registers are not separate storage. They are the bottom 32 bytes of the RAM, so bank b, register r is the byte at index b*8 + r.

An 8-bit address does not always name the same storage. In direct mode, an address of 0x80 or higher reaches the special-function window. In register-indirect mode, a pointer of 0x80 or higher is rejected and never reaches that window. The unit does not hold special-function contents itself. It raises a flag so that the core can send the access elsewhere, and it reads back zero for that access. Accesses to external data memory are passed out on their own request strobe and leave internal state untouched.

Top module: `idata_access_unit`

## Requirements
- R1: After a synchronous reset every RAM byte holds 0x00, so any read that follows returns 0x00.
- R2: With mode code 0 (register), the access reaches RAM index bank_sel*8 + reg_num, and the bank select picks which of the four 8-byte groups is used.
- R3: With mode code 1 (direct) and an address below 0x80, the access reaches the RAM byte at that address.
- R4: With mode code 1 and an address of 0x80 or above, sfr_hit is 1 and rd_data is 0x00; a write leaves every RAM byte unchanged.
- R5: With mode code 2 (register-indirect) and a pointer below 0x80, the access reaches the RAM byte at the pointer's low 7 bits.
- R6: With mode code 2 and a pointer of 0x80 or above, range_err is 1, sfr_hit is 0 and rd_data is 0x00; a write leaves RAM unchanged.
- R7: With mode code 3 (external indirect), ext_req is 1 while a strobe is active, rd_data is 0x00, the other flags are 0 and RAM is unchanged.
- R8: A write updates RAM on the rising clock edge. A read is combinational, so a read of the byte being written in the same cycle returns the old value, and the new value is returned from the next cycle on.
- R9: With rd_en and wr_en both 0, sfr_hit, range_err and ext_req are 0. Whenever rd_en is 0, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears the RAM |
| mode | input | 2 | Addressing mode: 0 register, 1 direct, 2 register-indirect, 3 external indirect |
| reg_num | input | 3 | Working register number used in register mode |
| addr | input | 8 | Direct address or pointer value |
| bank_sel | input | 2 | Active register bank |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| sfr_hit | output | 1 | Access is routed to the special-function window |
| range_err | output | 1 | Register-indirect pointer is outside the RAM |
| ext_req | output | 1 | Access is for external data memory |

## Verification
The bound checker checks the routing rules on every cycle. It confirms that the special-function flag appears only for a direct address with bit 7 set, that the out-of-range and external flags read zero and never overlap with other flags, that all flags are quiet when no strobe is active, and that a direct write is seen by a direct read of the same byte in the next cycle. The bench scenarios cover what depends on stored contents: that the three modes alias the same byte, that the bank select separates the register groups, and that a rejected pointer, a special-function write or an external write leaves the RAM unchanged, which is checked by reading the aliased bytes back.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 8;
    localparam int RAM_DEPTH     = 128;
    localparam int NUM_BANKS     = 4;
    localparam int REGS_PER_BANK = 8;

    localparam int RAM_IDX_W = $clog2(RAM_DEPTH);
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int REG_W     = $clog2(REGS_PER_BANK);

    typedef enum logic [1:0] {
        AM_REG          = 2'd0,
        AM_DIRECT       = 2'd1,
        AM_INDIRECT     = 2'd2,
        AM_EXT_INDIRECT = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_SFR  = 3'd2,
        TGT_OOR  = 3'd3,
        TGT_EXT  = 3'd4
    } target_e;

    typedef struct packed {
        target_e                tgt;
        logic [RAM_IDX_W-1:0]   idx;
    } route_t;

    // Working registers are laid out bank-major at the bottom of the RAM.
    function automatic logic [RAM_IDX_W-1:0] bank_reg_index(
        input logic [BANK_W-1:0] bank,
        input logic [REG_W-1:0]  regn
    );
        return RAM_IDX_W'({bank, regn});
    endfunction

endpackage

// File: rtl/idata_route.sv
module idata_route
    import idata_pkg::*;
#(
    parameter int P_ADDR_W    = ADDR_W,
    parameter int P_RAM_DEPTH = RAM_DEPTH
) (
    input  amode_e                mode,
    input  logic [REG_W-1:0]      reg_num,
    input  logic [P_ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]     bank_sel,
    input  logic                  strobe,
    output route_t                route
);

    localparam logic [P_ADDR_W-1:0] RAM_LIMIT = P_ADDR_W'(P_RAM_DEPTH);

    logic in_ram;
    assign in_ram = (addr < RAM_LIMIT);

    always_comb begin
        route.tgt = TGT_NONE;
        route.idx = addr[RAM_IDX_W-1:0];
        if (strobe) begin
            unique case (mode)
                AM_REG: begin
                    route.tgt = TGT_RAM;
                    route.idx = bank_reg_index(bank_sel, reg_num);
                end
                AM_DIRECT: begin
                    route.tgt = in_ram ? TGT_RAM : TGT_SFR;
                end
                AM_INDIRECT: begin
                    route.tgt = in_ram ? TGT_RAM : TGT_OOR;
                end
                AM_EXT_INDIRECT: begin
                    route.tgt = TGT_EXT;
                end
                default: route.tgt = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/idata_store.sv
module idata_store
    import idata_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_DEPTH  = RAM_DEPTH,
    localparam int IDX_W   = $clog2(P_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic [P_DATA_W-1:0]  wdata,
    output logic [P_DATA_W-1:0]  rdata
);

    logic [P_DATA_W-1:0] mem [P_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < P_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
    import idata_pkg::*;
#(
    parameter int P_DATA_W    = DATA_W,
    parameter int P_ADDR_W    = ADDR_W,
    parameter int P_RAM_DEPTH = RAM_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode,
    input  logic [REG_W-1:0]     reg_num,
    input  logic [P_ADDR_W-1:0]  addr,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [P_DATA_W-1:0]  wr_data,
    output logic [P_DATA_W-1:0]  rd_data,
    output logic                 sfr_hit,
    output logic                 range_err,
    output logic                 ext_req
);

    route_t              route;
    logic [P_DATA_W-1:0] ram_q;
    logic                ram_we;

    idata_route #(
        .P_ADDR_W    (P_ADDR_W),
        .P_RAM_DEPTH (P_RAM_DEPTH)
    ) u_route (
        .mode     (amode_e'(mode)),
        .reg_num  (reg_num),
        .addr     (addr),
        .bank_sel (bank_sel),
        .strobe   (rd_en | wr_en),
        .route    (route)
    );

    assign ram_we = wr_en && (route.tgt == TGT_RAM);

    idata_store #(
        .P_DATA_W (P_DATA_W),
        .P_DEPTH  (P_RAM_DEPTH)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .idx   (route.idx),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    assign rd_data   = (rd_en && route.tgt == TGT_RAM) ? ram_q : '0;
    assign sfr_hit   = (route.tgt == TGT_SFR);
    assign range_err = (route.tgt == TGT_OOR);
    assign ext_req   = (route.tgt == TGT_EXT);

endmodule

// File: rtl/idata_access_chk.sv
module idata_access_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic [7:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       sfr_hit,
    input logic       range_err,
    input logic       ext_req
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 8'h00);

    a_r4_sfr_only_direct: assert property (@(posedge clk) disable iff (rst)
        sfr_hit |-> (mode == 2'd1 && addr[7] && !range_err && !ext_req));

    a_r6_oor_reads_zero: assert property (@(posedge clk) disable iff (rst)
        range_err |-> (mode == 2'd2 && addr[7] && rd_data == 8'h00 && !sfr_hit));

    a_r7_ext_isolated: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (mode == 2'd3 && rd_data == 8'h00 && !sfr_hit && !range_err));

    a_r8_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && mode == 2'd1 && !addr[7])
         && rd_en && mode == 2'd1 && addr == $past(addr))
        |-> rd_data == $past(wr_data));

    a_r9_quiet_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (!sfr_hit && !range_err && !ext_req && rd_data == 8'h00));

endmodule

bind idata_access_unit idata_access_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .sfr_hit   (sfr_hit),
    .range_err (range_err),
    .ext_req   (ext_req)
);

// File: tb/idata_access_unit_tb.sv
`timescale 1ns/1ps
module idata_access_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic [2:0] reg_num = 3'd0;
    logic [7:0] addr = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sfr_hit;
    logic       range_err;
    logic       ext_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    idata_access_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .reg_num   (reg_num),
        .addr      (addr),
        .bank_sel  (bank_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .sfr_hit   (sfr_hit),
        .range_err (range_err),
        .ext_req   (ext_req)
    );

    // Expected outputs packed as {rd_data, sfr_hit, range_err, ext_req}
    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  model [128];

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    task automatic access(input logic [1:0] m, input logic [2:0] r,
                          input logic [7:0] a, input logic [1:0] b,
                          input logic rd, input logic wr,
                          input logic [7:0] wd, input string tag);
        logic [7:0] e_rd;
        logic       e_sfr, e_oor, e_ext, hit_ram;
        int         idx;
        @(negedge clk);
        mode = m; reg_num = r; addr = a; bank_sel = b;
        rd_en = rd; wr_en = wr; wr_data = wd;
        e_rd = 8'h00; e_sfr = 1'b0; e_oor = 1'b0; e_ext = 1'b0;
        hit_ram = 1'b0; idx = 0;
        if (rd || wr) begin
            case (m)
                2'd0: begin hit_ram = 1'b1; idx = int'(b) * 8 + int'(r); end
                2'd1: if (a < 8'h80) begin hit_ram = 1'b1; idx = int'(a); end
                      else e_sfr = 1'b1;
                2'd2: if (a < 8'h80) begin hit_ram = 1'b1; idx = int'(a); end
                      else e_oor = 1'b1;
                default: e_ext = 1'b1;
            endcase
        end
        if (rd && hit_ram) e_rd = model[idx];
        exp_q.push_back({e_rd, e_sfr, e_oor, e_ext});
        tag_q.push_back(tag);
        if (wr && hit_ram) model[idx] = wd;
    endtask

    task automatic idle();
        access(2'd1, 3'd0, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, "R9 idle");
    endtask

    // Monitor: compares each cycle a quarter period after the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                logic [10:0] e;
                logic [10:0] got;
                string       t;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                got = {rd_data, sfr_hit, range_err, ext_req};
                n_checks++;
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual rd=%02h sfr=%b oor=%b ext=%b expected rd=%02h sfr=%b oor=%b ext=%b",
                             t, got[10:3], got[2], got[1], got[0],
                             e[10:3], e[2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents read zero through every mode
        access(2'd1, 3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, "R1 direct 00");
        access(2'd1, 3'd0, 8'h7F, 2'd0, 1'b1, 1'b0, 8'h00, "R1 direct 7F");
        access(2'd0, 3'd7, 8'h00, 2'd3, 1'b1, 1'b0, 8'h00, "R1 reg b3r7");
        idle();

        // R2: fill all 32 working registers, read back via direct address
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++)
                access(2'd0, 3'(r), 8'h00, 2'(b), 1'b0, 1'b1, 8'(8'hA0 + b * 8 + r), "R2 reg write");
        for (int i = 0; i < 32; i++)
            access(2'd1, 3'd0, 8'(i), 2'd0, 1'b1, 1'b0, 8'h00, "R2 direct alias of reg");
        access(2'd0, 3'd5, 8'h00, 2'd2, 1'b1, 1'b0, 8'h00, "R2 reg b2r5");
        access(2'd0, 3'd5, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, "R2 reg b0r5 separate");

        // R3: direct RAM above the register area, read via indirect
        access(2'd1, 3'd0, 8'h7F, 2'd0, 1'b0, 1'b1, 8'h3C, "R3 direct write 7F");
        access(2'd2, 3'd0, 8'h7F, 2'd0, 1'b1, 1'b0, 8'h00, "R3 indirect read 7F");
        access(2'd1, 3'd0, 8'h30, 2'd0, 1'b0, 1'b1, 8'h5A, "R3 direct write 30");
        access(2'd1, 3'd0, 8'h30, 2'd0, 1'b1, 1'b0, 8'h00, "R3 direct read 30");

        // R5: indirect write, direct read
        access(2'd2, 3'd0, 8'h40, 2'd0, 1'b0, 1'b1, 8'h99, "R5 indirect write 40");
        access(2'd1, 3'd0, 8'h40, 2'd0, 1'b1, 1'b0, 8'h00, "R5 direct read 40");
        access(2'd2, 3'd0, 8'h08, 2'd0, 1'b1, 1'b0, 8'h00, "R5 indirect reads bank1 r0");

        // R4: SFR window only by direct, RAM aliases untouched
        access(2'd1, 3'd0, 8'h85, 2'd0, 1'b1, 1'b1, 8'hEE, "R4 sfr write 85");
        access(2'd1, 3'd0, 8'h05, 2'd0, 1'b1, 1'b0, 8'h00, "R4 alias 05 unchanged");
        access(2'd1, 3'd0, 8'hFF, 2'd0, 1'b1, 1'b0, 8'h00, "R4 sfr read FF");
        access(2'd1, 3'd0, 8'h7F, 2'd0, 1'b1, 1'b0, 8'h00, "R4 alias 7F unchanged");

        // R6: out-of-range pointer
        access(2'd2, 3'd0, 8'h90, 2'd0, 1'b0, 1'b1, 8'h77, "R6 oor write 90");
        access(2'd1, 3'd0, 8'h10, 2'd0, 1'b1, 1'b0, 8'h00, "R6 alias 10 unchanged");
        access(2'd2, 3'd0, 8'hC0, 2'd0, 1'b1, 1'b0, 8'h00, "R6 oor read C0");
        access(2'd1, 3'd0, 8'h40, 2'd0, 1'b1, 1'b0, 8'h00, "R6 alias 40 unchanged");

        // R7: external requests leave RAM alone
        access(2'd3, 3'd0, 8'h20, 2'd0, 1'b0, 1'b1, 8'h55, "R7 ext write 20");
        access(2'd3, 3'd0, 8'hA0, 2'd0, 1'b1, 1'b0, 8'h00, "R7 ext read A0");
        access(2'd1, 3'd0, 8'h20, 2'd0, 1'b1, 1'b0, 8'h00, "R7 alias 20 unchanged");

        // R8: same-cycle read sees old data, next cycle sees new
        access(2'd1, 3'd0, 8'h50, 2'd0, 1'b1, 1'b1, 8'h11, "R8 read during write");
        access(2'd1, 3'd0, 8'h50, 2'd0, 1'b1, 1'b1, 8'h22, "R8 next cycle new data");
        access(2'd1, 3'd0, 8'h50, 2'd0, 1'b1, 1'b0, 8'h00, "R8 settled");

        // R9: no strobe, no flags, zero data
        access(2'd1, 3'd0, 8'h90, 2'd0, 1'b0, 1'b0, 8'h00, "R9 no strobe sfr addr");
        access(2'd2, 3'd0, 8'hF0, 2'd0, 1'b0, 1'b0, 8'h00, "R9 no strobe oor ptr");
        access(2'd3, 3'd0, 8'h10, 2'd0, 1'b0, 1'b0, 8'h00, "R9 no strobe ext");
        access(2'd0, 3'd5, 8'h00, 2'd2, 1'b0, 1'b0, 8'h00, "R9 rd_en low data zero");
        idle();
        idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule